// File: doc/BRIEF.md
# GPIO Output Register Bank

This block owns the output side of an eight-pin general-purpose I/O port. A processor reaches it over a plain 32-bit memory-mapped bus that offers one access per cycle and never stalls. Two state words, the pin level and the pin drive enable, can each be loaded whole or modified bit by bit through atomic set and clear alias addresses. A read-modify-write sequence is then not needed when two agents share the port.

Each pin has two configuration words. The first chooses whether the pin level and the drive enable are inverted on their way to the pad. The second chooses between push-pull and open-drain drive. In open-drain mode a logic 1 becomes a released pin, and only a logic 0 is actively driven, as a low. The resulting per-pin level and enable go straight to the pad ring.

A global clock-enable bit gates all register writes except writes to itself. A read-only version word identifies the revision. The bus has no back-pressure. A read returns data in the same cycle it is presented, and a write takes effect at the next rising clock edge.

Top module: `gpo_bank`

## Requirements
- R1: After reset the level, enable and all per-pin configuration bits are 0, the clock-enable bit (0x3F8, bit 0) is 1, and pad_out and pad_oe are all 0.
- R2: A write to 0x04 loads the pin level word and a write to 0x10 loads the enable word. Bit n belongs to pin n. Reading either address returns the word in bits 7:0, and bits 31:8 read as 0 whatever was written.
- R3: Writing to 0x08 (level) or 0x14 (enable) sets every bit that is 1 in the write data and leaves the other bits unchanged.
- R4: Writing to 0x0C (level) or 0x18 (enable) clears every bit that is 1 in the write data and leaves the other bits unchanged.
- R5: The four alias addresses and every unmapped address read as 0.
- R6: The inversion word of pin n is at 0x2B0 + 4n. Bit 0 inverts the pin level and bit 2 inverts the drive enable. Only bits 0 and 2 are stored and read back.
- R7: The mode word of pin n is at 0x30 + 4n, and bit 2 selects open-drain when 1. It is the only stored bit. In open-drain mode, with v the level after inversion and e the enable after inversion, pad_oe = e AND NOT v and pad_out = 0.
- R8: In push-pull mode, pad_out equals the level after inversion and pad_oe equals the enable after inversion.
- R9: While the clock-enable bit is 0, writes to every address other than 0x3F8 change nothing. A write to 0x3F8 always updates the bit from write-data bit 0.
- R10: The word at 0x3FC always reads 0x2312010, and writes to it have no effect.
- R11: pad_out and pad_oe reflect a register write from the first cycle after the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte address (word aligned) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read strobe, else 0 |
| pad_out | output | 8 | Per-pin level to the pad |
| pad_oe | output | 8 | Per-pin drive enable to the pad |

## Verification
The hardest case to reach from the ports is one where several controls meet on a single pin: open-drain mode together with value inversion and enable inversion, while the clock-enable bit is low and writes are being ignored. A port where every pin sits in a different combination of those controls is also hard to produce. The stimulus first walks each alias and the gate in directed steps. It then runs a long random sequence over the mapped addresses, unmapped holes and full 32-bit data, and now and then turns the clock-enable bit off and back on. A behavioural model therefore meets every mix of mode, inversion and gating on all eight pins at once.

// File: rtl/gpo_pkg.sv
package gpo_pkg;
  localparam int unsigned OFS_LVL      = 'h004;
  localparam int unsigned OFS_LVL_SET  = 'h008;
  localparam int unsigned OFS_LVL_CLR  = 'h00C;
  localparam int unsigned OFS_EN       = 'h010;
  localparam int unsigned OFS_EN_SET   = 'h014;
  localparam int unsigned OFS_EN_CLR   = 'h018;
  localparam int unsigned OFS_MODE     = 'h030;
  localparam int unsigned OFS_INV      = 'h2B0;
  localparam int unsigned OFS_GATE     = 'h3F8;
  localparam int unsigned OFS_VER      = 'h3FC;
  localparam int unsigned STRIDE       = 4;
  localparam logic [27:0] VERSION_WORD = 28'h2312010;
endpackage

// File: rtl/gpo_regfile.sv
module gpo_regfile #(
  parameter int N_PINS = 8,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [N_PINS-1:0] lvl_q,
  output logic [N_PINS-1:0] en_q,
  output logic [N_PINS-1:0] inv_lvl_q,
  output logic [N_PINS-1:0] inv_en_q,
  output logic [N_PINS-1:0] od_q,
  output logic              gate_q
);
  import gpo_pkg::*;

  localparam logic [ADDR_W-1:0] A_GATE = ADDR_W'(OFS_GATE);

  logic [N_PINS-1:0] wv;
  logic              wr_any;
  logic              wr_ok;

  assign wv     = bus_wdata[N_PINS-1:0];
  assign wr_any = bus_en && bus_we;
  assign wr_ok  = wr_any && (gate_q || bus_addr == A_GATE);

  generate
    if (N_PINS < 32) begin : g_unused
      logic unused_hi;
      assign unused_hi = ^bus_wdata[31:N_PINS];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= '0;
      en_q   <= '0;
      gate_q <= 1'b1;
    end else if (wr_ok) begin
      if (bus_addr == ADDR_W'(OFS_LVL))     lvl_q <= wv;
      if (bus_addr == ADDR_W'(OFS_LVL_SET)) lvl_q <= lvl_q | wv;
      if (bus_addr == ADDR_W'(OFS_LVL_CLR)) lvl_q <= lvl_q & ~wv;
      if (bus_addr == ADDR_W'(OFS_EN))      en_q  <= wv;
      if (bus_addr == ADDR_W'(OFS_EN_SET))  en_q  <= en_q | wv;
      if (bus_addr == ADDR_W'(OFS_EN_CLR))  en_q  <= en_q & ~wv;
      if (bus_addr == A_GATE)               gate_q <= bus_wdata[0];
    end
  end

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin_cfg
    localparam logic [ADDR_W-1:0] A_INV  = ADDR_W'(OFS_INV + STRIDE * p);
    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFS_MODE + STRIDE * p);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        inv_lvl_q[p] <= 1'b0;
        inv_en_q[p]  <= 1'b0;
        od_q[p]      <= 1'b0;
      end else if (wr_ok) begin
        if (bus_addr == A_INV) begin
          inv_lvl_q[p] <= bus_wdata[0];
          inv_en_q[p]  <= bus_wdata[2];
        end
        if (bus_addr == A_MODE) od_q[p] <= bus_wdata[2];
      end
    end
  end
endmodule

// File: rtl/gpo_rd_mux.sv
module gpo_rd_mux #(
  parameter int N_PINS = 8,
  parameter int ADDR_W = 10
) (
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N_PINS-1:0] lvl_q,
  input  logic [N_PINS-1:0] en_q,
  input  logic [N_PINS-1:0] inv_lvl_q,
  input  logic [N_PINS-1:0] inv_en_q,
  input  logic [N_PINS-1:0] od_q,
  input  logic              gate_q,
  output logic [31:0]       rdata
);
  import gpo_pkg::*;

  always_comb begin
    rdata = '0;
    if (bus_en && !bus_we) begin
      if (bus_addr == ADDR_W'(OFS_LVL)) rdata[N_PINS-1:0] = lvl_q;
      if (bus_addr == ADDR_W'(OFS_EN))  rdata[N_PINS-1:0] = en_q;
      if (bus_addr == ADDR_W'(OFS_GATE)) rdata[0] = gate_q;
      if (bus_addr == ADDR_W'(OFS_VER))  rdata[27:0] = VERSION_WORD;
      for (int p = 0; p < N_PINS; p++) begin
        if (bus_addr == ADDR_W'(OFS_INV + STRIDE * p)) begin
          rdata[0] = inv_lvl_q[p];
          rdata[2] = inv_en_q[p];
        end
        if (bus_addr == ADDR_W'(OFS_MODE + STRIDE * p)) rdata[2] = od_q[p];
      end
    end
  end
endmodule

// File: rtl/gpo_pin_drive.sv
module gpo_pin_drive (
  input  logic lvl,
  input  logic en,
  input  logic inv_lvl,
  input  logic inv_en,
  input  logic open_drain,
  output logic po,
  output logic poe
);
  logic v;
  logic e;

  assign v   = lvl ^ inv_lvl;
  assign e   = en ^ inv_en;
  assign po  = open_drain ? 1'b0 : v;
  assign poe = open_drain ? (e & ~v) : e;
endmodule

// File: rtl/gpo_bank.sv
module gpo_bank #(
  parameter int N_PINS = 8,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [N_PINS-1:0] pad_out,
  output logic [N_PINS-1:0] pad_oe
);
  logic [N_PINS-1:0] lvl_q, en_q, inv_lvl_q, inv_en_q, od_q;
  logic              gate_q;

  gpo_regfile #(.N_PINS(N_PINS), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .lvl_q(lvl_q), .en_q(en_q), .inv_lvl_q(inv_lvl_q),
    .inv_en_q(inv_en_q), .od_q(od_q), .gate_q(gate_q)
  );

  gpo_rd_mux #(.N_PINS(N_PINS), .ADDR_W(ADDR_W)) rd_i (
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .lvl_q(lvl_q), .en_q(en_q), .inv_lvl_q(inv_lvl_q),
    .inv_en_q(inv_en_q), .od_q(od_q), .gate_q(gate_q),
    .rdata(bus_rdata)
  );

  for (genvar p = 0; p < N_PINS; p++) begin : g_drv
    gpo_pin_drive drv_i (
      .lvl(lvl_q[p]), .en(en_q[p]), .inv_lvl(inv_lvl_q[p]),
      .inv_en(inv_en_q[p]), .open_drain(od_q[p]),
      .po(pad_out[p]), .poe(pad_oe[p])
    );
  end
endmodule

// File: rtl/gpo_bank_chk.sv
module gpo_bank_chk #(
  parameter int N_PINS = 8,
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [N_PINS-1:0] pad_out,
  input logic [N_PINS-1:0] lvl_q,
  input logic [N_PINS-1:0] en_q,
  input logic [N_PINS-1:0] od_q,
  input logic              gate_q
);
  import gpo_pkg::*;

  // R3
  lvl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && gate_q && bus_addr == ADDR_W'(OFS_LVL_SET)) |=>
    ((lvl_q & $past(bus_wdata[N_PINS-1:0])) == $past(bus_wdata[N_PINS-1:0])));

  // R4
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && gate_q && bus_addr == ADDR_W'(OFS_EN_CLR)) |=>
    ((en_q & $past(bus_wdata[N_PINS-1:0])) == '0));

  // R9
  gated_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && !gate_q && bus_addr != ADDR_W'(OFS_GATE)) |=>
    ($stable(lvl_q) && $stable(en_q) && $stable(od_q) && !gate_q));

  // R7
  od_no_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out & od_q) == '0));

  // R10
  version_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && bus_addr == ADDR_W'(OFS_VER)) |->
    (bus_rdata == {4'h0, VERSION_WORD}));

  // R5
  alias_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && (bus_addr == ADDR_W'(OFS_LVL_SET) ||
      bus_addr == ADDR_W'(OFS_EN_CLR))) |-> (bus_rdata == '0));

  // R2
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && bus_addr == ADDR_W'(OFS_LVL)) |->
    (bus_rdata[31:N_PINS] == '0));
endmodule

bind gpo_bank gpo_bank_chk #(.N_PINS(N_PINS), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .pad_out(pad_out), .lvl_q(lvl_q), .en_q(en_q), .od_q(od_q),
  .gate_q(gate_q)
);

// File: tb/gpo_bank_tb_top.sv
`timescale 1ns/1ps
module gpo_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  pad_out, pad_oe;

  int checks = 0, fails = 0;
  bit done = 0;

  // behavioural reference state
  logic [7:0] m_lvl, m_en, m_iv, m_ie, m_od;
  logic       m_gate;

  always #2.5 clk = ~clk;

  gpo_bank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_lvl = 0; m_en = 0; m_iv = 0; m_ie = 0; m_od = 0; m_gate = 1;
  endtask

  function automatic logic [31:0] model_read(input int a);
    logic [31:0] r = 0;
    if (a == 'h04) r = {24'h0, m_lvl};
    if (a == 'h10) r = {24'h0, m_en};
    if (a == 'h3F8) r = {31'h0, m_gate};
    if (a == 'h3FC) r = 32'h02312010;
    for (int p = 0; p < 8; p++) begin
      if (a == 'h2B0 + 4*p) r = {29'h0, m_ie[p], 1'b0, m_iv[p]};
      if (a == 'h30 + 4*p)  r = {29'h0, m_od[p], 2'b00};
    end
    return r;
  endfunction

  task automatic wr(input int a, input logic [31:0] d);
    logic [7:0] w;
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = 10'(a); bus_wdata = d;
    @(posedge clk);
    #1;
    w = d[7:0];
    if (m_gate || a == 'h3F8) begin
      case (a)
        'h04: m_lvl = w;
        'h08: m_lvl = m_lvl | w;
        'h0C: m_lvl = m_lvl & ~w;
        'h10: m_en = w;
        'h14: m_en = m_en | w;
        'h18: m_en = m_en & ~w;
        'h3F8: m_gate = d[0];
        default: ;
      endcase
      for (int p = 0; p < 8; p++) begin
        if (a == 'h2B0 + 4*p) begin m_iv[p] = d[0]; m_ie[p] = d[2]; end
        if (a == 'h30 + 4*p) m_od[p] = d[2];
      end
    end
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input int a, input string req);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = 10'(a);
    #1;
    check(req, bus_rdata, model_read(a));
    @(posedge clk);
    #1;
    bus_en = 0;
  endtask

  // pad comparison on every clock (R7 R8 R11)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [7:0] v, e, xo, xe;
      v = m_lvl ^ m_iv;
      e = m_en ^ m_ie;
      xo = v & ~m_od;
      xe = (e & ~m_od) | (e & ~v & m_od);
      check("R7 R8 R11 pad_out", {24'h0, pad_out}, {24'h0, xo});
      check("R7 R8 R11 pad_oe", {24'h0, pad_oe}, {24'h0, xe});
    end
  end

  int addrs[18] = '{'h04, 'h08, 'h0C, 'h10, 'h14, 'h18, 'h30, 'h34, 'h4C,
                    'h2B0, 'h2B4, 'h2C8, 'h3F8, 'h3FC, 'h00, 'h1C, 'h2D0, 'h200};

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 pad_out reset", {24'h0, pad_out}, 0);
    check("R1 pad_oe reset", {24'h0, pad_oe}, 0);
    rd('h3F8, "R1 gate reset");
    rd('h04, "R1 lvl reset");
    rd('h2B0, "R1 inv reset");
    // R2 direct and upper bits
    wr('h04, 32'hFFFF_FFA5); rd('h04, "R2 lvl readback");
    wr('h10, 32'h1234_5633); rd('h10, "R2 en readback");
    // R3 set aliases
    wr('h08, 32'h0000_0042); rd('h04, "R3 lvl set");
    wr('h14, 32'hFFFF_FF0C); rd('h10, "R3 en set");
    // R4 clear aliases
    wr('h0C, 32'h0000_0081); rd('h04, "R4 lvl clr");
    wr('h18, 32'h0000_0030); rd('h10, "R4 en clr");
    // R5 aliases and holes
    rd('h08, "R5 alias"); rd('h14, "R5 alias"); rd('h18, "R5 alias"); rd('h1C, "R5 hole");
    // R6 inversion
    wr('h2B0, 32'hFFFF_FFFF); rd('h2B0, "R6 inv readback");
    wr('h2B4, 32'h0000_0004); rd('h2B4, "R6 inv enable only");
    // R7 open drain on several pins
    wr('h30, 32'h0000_0004); wr('h34, 32'h0000_0007); wr('h38, 32'h4);
    rd('h34, "R7 mode readback");
    wr('h10, 32'hFF); wr('h04, 32'h05);
    // R9 gate off
    wr('h3F8, 0); wr('h04, 32'hAA); wr('h14, 32'hFF); wr('h2B8, 32'h5);
    rd('h04, "R9 lvl frozen"); rd('h2B8, "R9 inv frozen"); rd('h3F8, "R9 gate low");
    wr('h3F8, 1); wr('h04, 32'h3C); rd('h04, "R9 resumed");
    // R10 version
    wr('h3FC, 0); rd('h3FC, "R10 version");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int a;
      logic [31:0] d;
      a = addrs[$urandom_range(17)];
      if (a == 'h30 || a == 'h2B0) a = a + 4 * $urandom_range(7);
      d = $urandom();
      if (a == 'h3F8 && ($urandom_range(3) != 0)) d[0] = 1'b1;
      if ($urandom_range(1) == 0) wr(a, d);
      else rd(a, "R2 R5 R6 R7 R9 random read");
    end
    wr('h3F8, 1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule